// File: doc/BRIEF.md
# Weighted Pseudo-Random Test Pattern Source

This block produces a small vector of test bits in which each bit has its own chance of being one. A plain maximal-length shift register with linear feedback gives unbiased bits, each equally likely to be zero or one. The block turns those bits into biased ones. It takes the logical AND of one to four distinct register bits for each output channel, and it can complement the result. Each channel can therefore give one with a chance of 1/2, 1/4, 1/8 or 1/16, or with the complement of any of these.

Every channel reads its own group of register bits, and no two groups overlap. All channels share one 16-stage register. The output is a registered pattern that moves forward once on each enabled clock edge. It is a free-running source with no back-pressure: a consumer that needs to stall it drives the enable low, and the pattern and register state then hold. The weight and invert settings are plain control inputs and may change at any edge.

Top module: `wprpg_top`

## Requirements
- R1: While `rst_i` is high at a rising edge, `pat_o` becomes all zeros and the register state is loaded with the seed 16'hACE1 (reset is synchronous, active high).
- R2: On each rising edge with `en_i` high and `rst_i` low, the state s moves to {s[14:0], s[15]^s[4]^s[2]^s[1]}. This is the polynomial x^16+x^5+x^3+x^2+1, which has a period of 65535. The state is never zero.
- R3: When `en_i` is low, neither `pat_o` nor the register state changes at a rising edge, even if the weight or invert inputs change.
- R4: Channel c is driven by bits 4c..4c+3 of the state and by the weight code `wt_sel_i[2c+1:2c]`. Code 0 passes bit 4c. Code 1 gives the AND of bits 4c and 4c+1. Code 2 gives the AND of bits 4c..4c+2. Code 3 gives the AND of bits 4c..4c+3.
- R5: When `wt_inv_i[c]` is 1, channel c gives the complement of its weighted bit.
- R6: Over one full period of 65535 enabled cycles with fixed settings, the fraction of ones on each channel is within 2% of its chance of being one. The chance is 2^-(code+1), or 1-2^-(code+1) when inverted. The exact count of ones is 2^(15-code), or 65535 minus that when inverted.
- R7: A change to the weight or invert inputs takes effect in `pat_o` at the next enabled edge, and it does not disturb the register sequence.
- R8: After an enabled edge, `pat_o` holds the weighted function of the register state as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance the register and the pattern |
| wt_sel_i | input | 2*NCH | Weight code per channel, two bits each |
| wt_inv_i | input | NCH | Complement per channel |
| pat_o | output | NCH | Weighted pattern, one bit per channel |

## Verification
The bench builds the block with its defaults: four channels on a 16-stage register, so the four channels use all 16 stages. Because 65535 cycles is a short run at this width, the bench can measure two full periods. Each period visits every nonzero state exactly once, so the count of ones on each channel is exact rather than a statistical estimate. Over the two periods, every weight code is measured both plain and inverted. A bench model of the register also follows the pattern cycle by cycle, across pauses of the enable and changes to the settings.

// File: rtl/wprpg_pkg.sv
package wprpg_pkg;
  typedef enum logic [1:0] {
    WT_HALF     = 2'd0,
    WT_QUARTER  = 2'd1,
    WT_EIGHTH   = 2'd2,
    WT_SIXTEENTH = 2'd3
  } wt_code_e;

  localparam int GRP = 4;
endpackage

// File: rtl/wprpg_lfsr.sv
module wprpg_lfsr #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'h8016,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] state_o
);
  logic fb;

  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk_i) begin
    if (rst_i)     state_o <= SEED;
    else if (en_i) state_o <= {state_o[WIDTH-2:0], fb};
  end
endmodule

// File: rtl/wprpg_chan.sv
module wprpg_chan
  import wprpg_pkg::*;
#(
  parameter int NBITS = GRP
) (
  input  logic [NBITS-1:0] bits_i,
  input  wt_code_e         code_i,
  input  logic             inv_i,
  output logic             bit_o
);
  logic [NBITS-1:0] use_m;

  always_comb begin
    for (int i = 0; i < NBITS; i++) use_m[i] = (i <= int'(code_i));
  end

  assign bit_o = (&(bits_i | ~use_m)) ^ inv_i;
endmodule

// File: rtl/wprpg_top.sv
module wprpg_top
  import wprpg_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'h8016,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [2*NCH-1:0] wt_sel_i,
  input  logic [NCH-1:0]   wt_inv_i,
  output logic [NCH-1:0]   pat_o
);
  localparam int USED = NCH * GRP;

  logic [WIDTH-1:0] lfsr_q;
  logic [NCH-1:0]   pat_d;

  wprpg_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .state_o(lfsr_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wprpg_chan #(.NBITS(GRP)) u_chan (
      .bits_i(lfsr_q[c*GRP +: GRP]),
      .code_i(wt_code_e'(wt_sel_i[2*c +: 2])),
      .inv_i (wt_inv_i[c]),
      .bit_o (pat_d[c])
    );
  end

  if (WIDTH > USED) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^lfsr_q[WIDTH-1:USED];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     pat_o <= '0;
    else if (en_i) pat_o <= pat_d;
  end
endmodule

// File: rtl/wprpg_chk.sv
module wprpg_chk #(
  parameter int NCH   = 4,
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic [2*NCH-1:0] wt_sel_i,
  input logic [NCH-1:0]   wt_inv_i,
  input logic [NCH-1:0]   pat_o,
  input logic [WIDTH-1:0] state_i
);
  // R2
  state_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    state_i != '0);

  // R2
  state_moves_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> state_i != $past(state_i));

  // R3
  pat_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ($stable(pat_o) && $stable(state_i)));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R4
    full_and_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && wt_sel_i[2*c +: 2] == 2'd3 && !wt_inv_i[c])
        |=> (pat_o[c] == &$past(state_i[4*c +: 4])));
    // R5
    inv_half_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && wt_sel_i[2*c +: 2] == 2'd0 && wt_inv_i[c])
        |=> (pat_o[c] != $past(state_i[4*c])));
  end
endmodule

bind wprpg_top wprpg_chk #(.NCH(NCH), .WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .en_i    (en_i),
  .wt_sel_i(wt_sel_i),
  .wt_inv_i(wt_inv_i),
  .pat_o   (pat_o),
  .state_i (lfsr_q)
);

// File: tb/sim_wprpg_top.sv
module sim_wprpg_top;
  localparam int NCH = 4;
  localparam int PERIOD = 65535;

  // Measurement table: weight codes and inverts per window, channel 0 in the low bits.
  localparam logic [7:0] WSEL_TAB [0:1] = '{8'b11_10_01_00, 8'b00_01_10_11};
  localparam logic [3:0] INV_TAB  [0:1] = '{4'b0000, 4'b1111};

  logic clk = 0, rst = 1, en = 0;
  logic [2*NCH-1:0] wsel = '0;
  logic [NCH-1:0] inv = '0;
  logic [NCH-1:0] pat;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] ref_s = 16'hACE1;
  logic [NCH-1:0] exp_pat = '0;

  always #5 clk = ~clk;

  wprpg_top #(.NCH(NCH)) u0 (
    .clk_i(clk), .rst_i(rst), .en_i(en),
    .wt_sel_i(wsel), .wt_inv_i(inv), .pat_o(pat)
  );

  function automatic logic [NCH-1:0] weigh(input logic [15:0] s,
      input logic [2*NCH-1:0] w, input logic [NCH-1:0] iv);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) begin
      logic b;
      b = 1'b1;
      for (int k = 0; k <= int'(w[2*c +: 2]); k++) b &= s[4*c + k];
      r[c] = b ^ iv[c];
    end
    return r;
  endfunction

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Drive one edge from a negedge; model the expected pattern; returns after the next negedge.
  task automatic tick();
    if (en) begin
      exp_pat = weigh(ref_s, wsel, inv);
      ref_s = step(ref_s);
    end
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset clears the pattern
    check("R1", pat, 0);
    rst = 0;

    // R4 R5 R8: per-cycle match with mixed settings
    en = 1; wsel = 8'b11_10_01_00; inv = 4'b1010;
    for (int i = 0; i < 30; i++) tick();
    check("R4 R5 R8 mixed", pat, exp_pat);
    wsel = 8'b00_00_00_00; inv = 4'b0000;
    tick();
    check("R4 code0 plain", pat, exp_pat);
    inv = 4'b1111;
    tick();
    check("R5 code0 inverted", pat, exp_pat);

    // R3: enable low, settings change, nothing moves
    en = 0;
    begin
      logic [NCH-1:0] held;
      held = pat;
      wsel = 8'b11_11_11_11; inv = 4'b0101;
      for (int i = 0; i < 5; i++) tick();
      check("R3 hold pattern", pat, held);
    end

    // R7: new settings apply at the next enabled edge, sequence undisturbed
    en = 1;
    tick();
    check("R7 first edge after change", pat, exp_pat);
    wsel = 8'b01_10_11_00; inv = 4'b0011;
    tick();
    check("R7 second change", pat, exp_pat);
    for (int i = 0; i < 10; i++) tick();
    check("R2 R7 sequence intact", pat, exp_pat);

    // R6 R2: full-period counts from the table
    for (int t = 0; t < 2; t++) begin
      int cnt [NCH];
      int mism;
      mism = 0;
      for (int c = 0; c < NCH; c++) cnt[c] = 0;
      wsel = WSEL_TAB[t]; inv = INV_TAB[t];
      for (int i = 0; i < PERIOD; i++) begin
        tick();
        if (pat !== exp_pat) mism++;
        for (int c = 0; c < NCH; c++) cnt[c] += int'(pat[c]);
      end
      check("R2 R8 period trace", mism, 0);
      for (int c = 0; c < NCH; c++) begin
        int code, ones, expc;
        real p, f;
        code = int'(wsel[2*c +: 2]);
        ones = 1 << (15 - code);
        expc = inv[c] ? PERIOD - ones : ones;
        p = 1.0 / real'(1 << (code + 1));
        if (inv[c]) p = 1.0 - p;
        f = real'(cnt[c]) / real'(PERIOD);
        check("R6 exact count", cnt[c], expc);
        checks++;
        if (f - p > 0.02 || p - f > 0.02) begin
          fails++;
          $display("FAIL R6 fraction actual=%f expected=%f", f, p);
        end
      end
    end

    // R1: reset mid-run restores zero output and seed sequence
    rst = 1;
    tick();
    check("R1 reset mid-run", pat, 0);
    rst = 0; ref_s = 16'hACE1; wsel = '0; inv = '0;
    tick();
    check("R1 R2 seed restart", pat, exp_pat);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule